// File: doc/BRIEF.md
# Stall-Driven Spare-Stage Repair Controller

This block supervises a linear pipeline made of `LANES` working stages and `SPARES` spare stages, which gives `LANES+SPARES` physical positions. A faulty stage stalls and never emits a wrong result, so the only sign of trouble is that handshakes stop. The controller counts consecutive cycles in which no in-use stage shows handshake activity. When that count reaches a programmable limit, it treats the array as deadlocked and inspects the per-stage fault and pending flags to pick one stage to blame.

The blamed stage is retired. The logical pipeline is then laid again over the lowest non-retired physical positions, in ascending order, so that each stage beyond the retired one moves onto the next free position. After this the controller sends the host a one-cycle restart request, and the host resumes from the start or from a checkpoint. If a culprit is found after every spare has been used, the controller enters a terminal state and raises a sticky unrecoverable flag. While the array keeps handshaking, nothing in the controller changes. All pins are plain control and status levels: no data passes through the block, so there is no valid/ready stream and no back-pressure.

Top module: `array_repair_ctrl`

## Requirements
- R1: After reset, `stage_active` enables exactly physical positions 0 to `LANES-1` (6'b001111 with defaults), and `req_restart` and `array_dead` are 0.
- R2: Only activity on positions where `stage_active` is 1 counts as progress. Deadlock is declared once `stall_limit` consecutive clock edges have sampled no such activity. A limit of 0 behaves like a limit of 1.
- R3: The culprit is the lowest-indexed active position with its fault bit set. If no such position exists, it is the lowest-indexed active position with `in_vld`=1 and `in_ack`=0. Flags on inactive positions are ignored.
- R4: A culprit is retired for good. `stage_active` then enables the lowest `LANES` non-retired positions.
- R5: When a culprit is found, `req_restart` is high in the window after edge `stall_limit+2`, counted from the first idle edge. The new `stage_active` is visible in that same window.
- R6: If no culprit is found, `req_restart` is raised after edge `stall_limit+1` and `stage_active` is unchanged.
- R7: Up to `SPARES` faults are repaired one after another. A culprit found after all spares are used drives `array_dead` high after edge `stall_limit+1`. `array_dead` stays high until reset, no restart is issued, and `stage_active` stays frozen.
- R8: While active positions keep handshaking, `stage_active` and `req_restart` do not change.
- R9: `req_restart` is exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stall_limit | input | TO_W | Idle cycles that declare deadlock |
| hs_act | input | LANES+SPARES | Per-position handshake activity this cycle |
| flt | input | LANES+SPARES | Per-position fault flag |
| in_vld | input | LANES+SPARES | Position holds valid input |
| in_ack | input | LANES+SPARES | Position has acknowledged its input |
| stage_active | output | LANES+SPARES | Switch enables: 1 = position carries a logical stage |
| req_restart | output | 1 | One-cycle request to restart the computation |
| array_dead | output | 1 | Sticky unrecoverable flag |

## Verification
The culprit search is tried with four kinds of pattern, each starting from a clean reset: a single fault bit, a pending-but-unacknowledged input alone, a fault and a pending position together, and flags raised only on spare positions. These separate the fault-over-pending priority, the lowest-index rule and the masking of inactive positions. Latency runs at limits 5, 1 and 0 separate the found and not-found paths and probe the counter boundary. Toggles placed only on spare positions show that progress outside the active set is ignored. A run of three faults in a row, without reset, checks the remapping after two repairs and then the terminal state when the spares run out.

// File: rtl/arc_pkg.sv
package arc_pkg;
  typedef enum logic [2:0] {
    ST_MONITOR,
    ST_LOCATE,
    ST_RECONF,
    ST_RESTART,
    ST_FAILED
  } arc_state_e;
endpackage

// File: rtl/arc_stall_timer.sv
module arc_stall_timer #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_clear,
  input  logic            activity,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);
  logic [TO_W-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      idle_cnt <= '0;
    else if (hold_clear || activity) idle_cnt <= '0;
    else if (idle_cnt != '1)         idle_cnt <= idle_cnt + 1'b1;
  end

  assign expired = !hold_clear && !activity &&
                   (({1'b0, idle_cnt} + (TO_W+1)'(1)) >= {1'b0, limit});

  AST_ACTIVITY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> (idle_cnt == '0)); // R2
endmodule

// File: rtl/arc_culprit_finder.sv
module arc_culprit_finder #(
  parameter int PHYS  = 6,
  parameter int IDX_W = 3
) (
  input  logic [PHYS-1:0]  active,
  input  logic [PHYS-1:0]  flt,
  input  logic [PHYS-1:0]  in_vld,
  input  logic [PHYS-1:0]  in_ack,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [PHYS-1:0]  flt_m, pend_m;
  logic             f_hit, p_hit;
  logic [IDX_W-1:0] f_idx, p_idx;

  genvar g;
  generate
    for (g = 0; g < PHYS; g++) begin : g_mask
      assign flt_m[g]  = active[g] & flt[g];
      assign pend_m[g] = active[g] & in_vld[g] & ~in_ack[g];
    end
  endgenerate

  always_comb begin
    f_hit = 1'b0; f_idx = '0;
    p_hit = 1'b0; p_idx = '0;
    for (int i = PHYS-1; i >= 0; i--) begin
      if (flt_m[i])  begin f_hit = 1'b1; f_idx = IDX_W'(i); end
      if (pend_m[i]) begin p_hit = 1'b1; p_idx = IDX_W'(i); end
    end
  end

  assign found = f_hit | p_hit;
  assign idx   = f_hit ? f_idx : p_idx;

  AST_FAULT_FIRST: assert final (!(|flt_m) || (found && flt_m[idx])); // R3
endmodule

// File: rtl/arc_lane_mapper.sv
module arc_lane_mapper #(
  parameter int LANES = 4,
  parameter int PHYS  = 6
) (
  input  logic [PHYS-1:0] retired,
  output logic [PHYS-1:0] active
);
  localparam int CW = $clog2(PHYS+1);
  localparam logic [CW-1:0] LANES_C = CW'(LANES);

  logic [CW-1:0] taken;

  always_comb begin
    taken  = '0;
    active = '0;
    for (int p = 0; p < PHYS; p++) begin
      if (!retired[p]) begin
        active[p] = (taken < LANES_C);
        taken     = taken + 1'b1;
      end
    end
  end
endmodule

// File: rtl/array_repair_ctrl.sv
module array_repair_ctrl
  import arc_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int SPARES = 2,
  parameter int TO_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TO_W-1:0]         stall_limit,
  input  logic [LANES+SPARES-1:0] hs_act,
  input  logic [LANES+SPARES-1:0] flt,
  input  logic [LANES+SPARES-1:0] in_vld,
  input  logic [LANES+SPARES-1:0] in_ack,
  output logic [LANES+SPARES-1:0] stage_active,
  output logic                    req_restart,
  output logic                    array_dead
);
  localparam int PHYS  = LANES + SPARES;
  localparam int IDX_W = (PHYS > 1) ? $clog2(PHYS) : 1;
  localparam int UW    = $clog2(SPARES+1);
  localparam logic [UW-1:0] SPARES_C = UW'(SPARES);

  arc_state_e       state, state_nx;
  logic [PHYS-1:0]  retired;
  logic [UW-1:0]    used;
  logic [IDX_W-1:0] culprit_q, cand_idx;
  logic             cand_found, expired;

  arc_stall_timer #(.TO_W(TO_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .hold_clear(state != ST_MONITOR),
    .activity(|(hs_act & stage_active)),
    .limit(stall_limit),
    .expired(expired)
  );

  arc_culprit_finder #(.PHYS(PHYS), .IDX_W(IDX_W)) u_find (
    .active(stage_active), .flt(flt), .in_vld(in_vld), .in_ack(in_ack),
    .found(cand_found), .idx(cand_idx)
  );

  arc_lane_mapper #(.LANES(LANES), .PHYS(PHYS)) u_map (
    .retired(retired), .active(stage_active)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_MONITOR: if (expired) state_nx = ST_LOCATE;
      ST_LOCATE: begin
        if (!cand_found)            state_nx = ST_RESTART;
        else if (used == SPARES_C)  state_nx = ST_FAILED;
        else                        state_nx = ST_RECONF;
      end
      ST_RECONF:  state_nx = ST_RESTART;
      ST_RESTART: state_nx = ST_MONITOR;
      ST_FAILED:  state_nx = ST_FAILED;
      default:    state_nx = ST_MONITOR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_MONITOR;
      retired   <= '0;
      used      <= '0;
      culprit_q <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_LOCATE) culprit_q <= cand_idx;
      if (state == ST_RECONF) begin
        retired[culprit_q] <= 1'b1;
        used               <= used + 1'b1;
      end
    end
  end

  assign req_restart = (state == ST_RESTART);
  assign array_dead  = (state == ST_FAILED);

  AST_EN_ONLY_IN_RECONF: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RECONF) |=> $stable(stage_active)); // R4
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stage_active) == LANES); // R4
  AST_RETIRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(retired) <= SPARES); // R7
  AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    array_dead |=> (array_dead && !req_restart)); // R7
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_restart |=> !req_restart); // R9
  AST_PROGRESS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MONITOR && |(hs_act & stage_active)) |=> (state == ST_MONITOR)); // R8
endmodule

// File: tb/test_array_repair_ctrl.sv
`timescale 1ns/1ps
module test_array_repair_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] stall_limit = 8'd5;
  logic [5:0] hs_act = '1, flt = '0, in_vld = '0, in_ack = '0;
  logic [5:0] stage_active;
  logic       req_restart, array_dead;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  array_repair_ctrl #(.LANES(4), .SPARES(2), .TO_W(8)) i_array_repair_ctrl (
    .clk(clk), .rst_n(rst_n), .stall_limit(stall_limit), .hs_act(hs_act),
    .flt(flt), .in_vld(in_vld), .in_ack(in_ack), .stage_active(stage_active),
    .req_restart(req_restart), .array_dead(array_dead)
  );

  // Table: fault, valid, ack masks -> expected enables and latency at limit 5
  localparam int NV = 7;
  localparam logic [5:0] T_FLT [NV] = '{6'b000100, 6'b000000, 6'b000010, 6'b110000,
                                        6'b000000, 6'b001001, 6'b000000};
  localparam logic [5:0] T_VLD [NV] = '{6'b000000, 6'b001000, 6'b000001, 6'b000000,
                                        6'b000011, 6'b000000, 6'b100000};
  localparam logic [5:0] T_ACK [NV] = '{6'b000000, 6'b000000, 6'b000000, 6'b000000,
                                        6'b000001, 6'b000000, 6'b000000};
  localparam logic [5:0] T_EN  [NV] = '{6'b011011, 6'b010111, 6'b011101, 6'b001111,
                                        6'b011101, 6'b011110, 6'b001111};
  localparam int         T_LAT [NV] = '{7, 7, 7, 6, 7, 7, 6};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hs_act = '1; flt = '0; in_vld = '0; in_ack = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic stall(input logic [7:0] lim, input logic [5:0] hs, input logic [5:0] f,
                       input logic [5:0] v, input logic [5:0] a, input logic [5:0] exp_en,
                       input int exp_lat, input bit exp_dead, input string req);
    int n = 0;
    bit done = 1'b0;
    @(negedge clk);
    stall_limit = lim; hs_act = hs; flt = f; in_vld = v; in_ack = a;
    while (!done && n < 400) begin
      @(posedge clk); @(negedge clk);
      n++;
      if (req_restart || array_dead) done = 1'b1;
    end
    check(n == exp_lat, req, "latency", n, exp_lat);
    check(stage_active == exp_en, req, "stage_active", int'(stage_active), int'(exp_en));
    if (exp_dead)
      check(array_dead && !req_restart, req, "dead/no restart",
            int'({array_dead, req_restart}), 2);
    else begin
      check(req_restart && !array_dead, req, "restart raised",
            int'({array_dead, req_restart}), 1);
      @(posedge clk); @(negedge clk);
      check(!req_restart, "R9", "restart width", int'(req_restart), 0);
    end
    hs_act = '1; flt = '0; in_vld = '0; in_ack = '0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit quiet_ok;
    logic [5:0] en0;
    do_reset();
    // R1 reset state
    check(stage_active == 6'b001111, "R1", "reset enables", int'(stage_active), 15);
    check(!req_restart && !array_dead, "R1", "reset flags",
          int'({array_dead, req_restart}), 0);

    // R8 steady handshaking leaves everything alone
    quiet_ok = 1'b1; en0 = stage_active;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (req_restart || array_dead || stage_active != en0) quiet_ok = 1'b0;
    end
    check(quiet_ok, "R8", "quiet while running", int'(quiet_ok), 1);

    // R3 R4 R5 R6 table of culprit patterns
    for (int k = 0; k < NV; k++) begin
      do_reset();
      stall(8'd5, 6'b000000, T_FLT[k], T_VLD[k], T_ACK[k], T_EN[k], T_LAT[k], 1'b0,
            (T_LAT[k] == 6) ? "R6" : "R3");
    end

    // R2 activity on spare positions only is not progress
    do_reset();
    stall(8'd5, 6'b110000, 6'b000001, '0, '0, 6'b011110, 7, 1'b0, "R2");
    // R2 limit boundaries: 1 and 0 both give found latency 3
    do_reset();
    stall(8'd1, 6'b000000, 6'b000100, '0, '0, 6'b011011, 3, 1'b0, "R2");
    do_reset();
    stall(8'd0, 6'b000000, 6'b000100, '0, '0, 6'b011011, 3, 1'b0, "R2");

    // R7 successive faults, then exhaustion
    do_reset();
    stall(8'd5, 6'b000000, 6'b000100, '0, '0, 6'b011011, 7, 1'b0, "R4");
    repeat (5) @(negedge clk);
    stall(8'd5, 6'b000000, 6'b010000, '0, '0, 6'b101011, 7, 1'b0, "R7");
    repeat (5) @(negedge clk);
    stall(8'd5, 6'b000000, 6'b000001, '0, '0, 6'b101011, 6, 1'b1, "R7");
    quiet_ok = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (!array_dead || req_restart || stage_active != 6'b101011) quiet_ok = 1'b0;
    end
    check(quiet_ok, "R7", "terminal state holds", int'(quiet_ok), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule